// File: doc/BRIEF.md
# Edge-Selectable Interrupt Status Controller

The block gathers sixteen single-bit event lines into one interrupt request. Each line first passes through a clock-domain synchroniser. A change on a line is then compared with its previous synchronised value to find rising and falling transitions. Two independent enable masks choose, per source, whether a rising change, a falling change, or both are recorded. Recorded events stay in a sticky status register until software acknowledges them.

Software acknowledges events with a two-step handshake on a clear register. It first writes a mask of the bits to drop, then writes zero. While a bit of the clear register is one, the matching status bit is forced low, so an edge that arrives in that window is discarded. The interrupt output is the registered OR of all status bits, which gives the host a clean rising edge to sense.

One source position is dedicated to the converter-done strobe. That position takes its value from a separate input, not from the general event bus. All registers are reached over a plain synchronous bus with an address, a write strobe, write data and combinational read data.

Top module: `edge_irq_ctrl`

## Requirements
- R1: There are 16 source positions; bit i of the event bus, of both enable masks, of the status register and of the clear register all refer to the same source i (0 to 15).
- R2: The rising-enable mask sits at address 0 (read/write). A source whose bit is set records a 0-to-1 change of its synchronised input into its status bit.
- R3: The falling-enable mask sits at address 1 (read/write). A source whose bit is set records a 1-to-0 change. With both mask bits set, either change is recorded.
- R4: The status register sits at address 2 and is read-only: bus writes to address 2 leave it unchanged. A recorded bit stays set until cleared. A source with neither mask bit set never sets its bit.
- R5: The clear register sits at address 3 (read/write). While one of its bits is 1, the matching status bit is 0 from the next cycle on, and edges in that window are lost. Writing zero ends the hold, and later edges are recorded again.
- R6: The interrupt output is a register holding the OR of the status bits. It is high in the cycle after any status bit is high, and low in the cycle after all status bits are low.
- R7: An edge on an event input that is first sampled at clock edge k shows in the status register after clock edge k+2: two synchroniser flops, with detection against the previous synchronised value.
- R8: Reset (synchronous, active high) clears both enable masks, the status register, the clear register, the synchroniser flops and the interrupt output.
- R9: Source position 11 takes its value from the converter-done input. Bit 11 of the general event bus has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | 16 | Asynchronous event lines, one per source (bit 11 unused) |
| adc_done | input | 1 | Converter-done strobe, routed to source 11 |
| bus_addr | input | 2 | Register select: 0 rise mask, 1 fall mask, 2 status, 3 clear |
| bus_we | input | 1 | Write strobe, taken at the rising clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Contents of the selected register (combinational) |
| irq | output | 1 | Interrupt request, registered OR of the status bits |

## Verification
A wrong enable or clear bit shows at the ports three cycles after a matching input edge at the latest. It appears as a status bit that is set or missing when address 2 is read, and one cycle later as a wrong interrupt level. A slip in the synchroniser depth moves the first visible status change by a cycle, so the bench compares the read data and the interrupt against a cycle-exact reference on every clock. Lost edges during a clear hold, and writes aimed at the read-only status, are checked by reading the status in the cycles that follow the stimulus.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
    localparam int SRC_N    = 16;
    localparam int ADDR_W   = 2;
    localparam int SYNC_N   = 2;
    localparam int ADC_SLOT = 11;

    typedef logic [SRC_N-1:0] src_vec_t;

    typedef enum logic [ADDR_W-1:0] {
        SEL_RISE = 2'd0,
        SEL_FALL = 2'd1,
        SEL_STAT = 2'd2,
        SEL_CLR  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        src_vec_t rise;
        src_vec_t fall;
    } edge_pair_t;

    typedef struct packed {
        src_vec_t rise_en;
        src_vec_t fall_en;
        src_vec_t clr;
    } ctrl_t;

    // Sources whose detected edge matches an enabled direction
    function automatic src_vec_t edge_hits(edge_pair_t e, ctrl_t c);
        return (e.rise & c.rise_en) | (e.fall & c.fall_en);
    endfunction
endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync
    import irq_ctrl_pkg::*;
#(
    parameter int STAGES = SYNC_N
) (
    input  logic       clk,
    input  logic       rst,
    input  src_vec_t   raw,
    output edge_pair_t edges
);
    src_vec_t chain [STAGES];
    src_vec_t prev_q;

    // R7: STAGES synchroniser flops, then one more for the previous value
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
            prev_q <= '0;
        end else begin
            chain[0] <= raw;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            prev_q <= chain[STAGES-1];
        end
    end

    always_comb begin
        edges.rise = chain[STAGES-1] & ~prev_q;
        edges.fall = ~chain[STAGES-1] & prev_q;
    end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  src_vec_t          wdata,
    input  src_vec_t          stat,
    output ctrl_t             ctrl,
    output src_vec_t          rdata
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    // R2 R3 R5: writable masks; R4: status address has no write target
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (we) begin
            case (sel)
                SEL_RISE: ctrl.rise_en <= wdata;
                SEL_FALL: ctrl.fall_en <= wdata;
                SEL_CLR:  ctrl.clr     <= wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_RISE: rdata = ctrl.rise_en;
            SEL_FALL: rdata = ctrl.fall_en;
            SEL_STAT: rdata = stat;
            default:  rdata = ctrl.clr;
        endcase
    end
endmodule

// File: rtl/irq_status.sv
module irq_status
    import irq_ctrl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t hits,
    input  src_vec_t clr,
    output src_vec_t stat,
    output logic     irq
);
    src_vec_t stat_d;

    // R5: clear hold wins over a new hit in the same cycle
    assign stat_d = (stat | hits) & ~clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
            irq  <= 1'b0;
        end else begin
            stat <= stat_d;
            irq  <= |stat;   // R6: registered OR
        end
    end
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int DONE_SLOT  = ADC_SLOT,
    parameter int SYNC_DEPTH = SYNC_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SRC_N-1:0]  evt_in,
    input  logic              adc_done,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [SRC_N-1:0]  bus_wdata,
    output logic [SRC_N-1:0]  bus_rdata,
    output logic              irq
);
    src_vec_t   raw_src;
    edge_pair_t edges;
    ctrl_t      ctrl;
    src_vec_t   stat_q;
    src_vec_t   hits;

    // R9: converter-done strobe replaces its bus position; R1: one bit per source
    always_comb begin
        raw_src            = evt_in;
        raw_src[DONE_SLOT] = adc_done;
    end

    irq_src_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .raw   (raw_src),
        .edges (edges)
    );

    irq_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .addr  (bus_addr),
        .we    (bus_we),
        .wdata (bus_wdata),
        .stat  (stat_q),
        .ctrl  (ctrl),
        .rdata (bus_rdata)
    );

    assign hits = edge_hits(edges, ctrl);

    irq_status u_stat (
        .clk  (clk),
        .rst  (rst),
        .hits (hits),
        .clr  (ctrl.clr),
        .stat (stat_q),
        .irq  (irq)
    );
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
    import irq_ctrl_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input src_vec_t stat,
    input src_vec_t clr,
    input src_vec_t rise_en,
    input src_vec_t fall_en,
    input logic     irq
);
    AST_IRQ_RISES: assert property (@(posedge clk) disable iff (rst)
        (|stat) |=> irq); // R6
    AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (rst)
        (stat == '0) |=> !irq); // R6
    AST_CLR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (|clr) |=> ((stat & $past(clr)) == '0)); // R5
    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (|(stat & ~clr)) |=> ((stat & $past(stat & ~clr)) == $past(stat & ~clr))); // R4
    AST_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (|(stat | ~stat)) |=> ((stat & ~$past(stat) & ~$past(rise_en | fall_en)) == '0)); // R2
endmodule

bind edge_irq_ctrl irq_ctrl_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .stat    (stat_q),
    .clr     (ctrl.clr),
    .rise_en (ctrl.rise_en),
    .fall_en (ctrl.fall_en),
    .irq     (irq)
);

// File: tb/edge_irq_ctrl_tb.sv
module edge_irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] evt_in = '0;
    logic        adc_done = 1'b0;
    logic [1:0]  bus_addr = 2'd2;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;   // 50 MHz

    edge_irq_ctrl dut_i (
        .clk(clk), .rst(rst), .evt_in(evt_in), .adc_done(adc_done),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    // ---------------- behavioural reference ----------------
    logic [15:0] hist[$];
    logic [15:0] m_re, m_fe, m_clr, m_stat;
    logic        m_irq;

    function automatic logic [15:0] model_read(input logic [1:0] a);
        case (a)
            2'd0: return m_re;
            2'd1: return m_fe;
            2'd2: return m_stat;
            default: return m_clr;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [15:0] eff, r, f, ns;
        if (rst) begin
            hist = '{16'h0, 16'h0, 16'h0, 16'h0};
            m_re = 0; m_fe = 0; m_clr = 0; m_stat = 0; m_irq = 0;
        end else begin
            eff = evt_in;
            eff[11] = adc_done;
            hist.push_front(eff);
            void'(hist.pop_back());
            r  = hist[2] & ~hist[3];
            f  = ~hist[2] & hist[3];
            ns = (m_stat | (r & m_re) | (f & m_fe)) & ~m_clr;
            m_irq  = |m_stat;
            m_stat = ns;
            if (bus_we) begin
                case (bus_addr)
                    2'd0: m_re  = bus_wdata;
                    2'd1: m_fe  = bus_wdata;
                    2'd3: m_clr = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison
    always @(negedge clk) begin
        if (!rst) begin
            case (bus_addr)
                2'd0: chk(bus_rdata, model_read(bus_addr), "R2 rise mask read");
                2'd1: chk(bus_rdata, model_read(bus_addr), "R3 fall mask read");
                2'd2: chk(bus_rdata, model_read(bus_addr), "R4 status read");
                default: chk(bus_rdata, model_read(bus_addr), "R5 clear read");
            endcase
            chk({15'h0, irq}, {15'h0, m_irq}, "R6 irq level");
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(posedge clk); #5;
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk); #5;
        bus_we = 1'b0; bus_addr = 2'd2;
    endtask

    task automatic set_evt(input logic [15:0] v);
        @(posedge clk); #5;
        evt_in = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic ack(input logic [15:0] m);
        wr(2'd3, m);
        wr(2'd3, 16'h0);
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle(3);
        @(posedge clk); #5; rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        chk(bus_rdata, 16'h0, "R8 status after reset");
        chk({15'h0, irq}, 16'h0, "R8 irq after reset");
        bus_addr = 2'd0; #1; chk(bus_rdata, 16'h0, "R8 rise mask after reset");
        bus_addr = 2'd3; #1; chk(bus_rdata, 16'h0, "R8 clear after reset");
        bus_addr = 2'd2;

        // R4: no enables -> toggles never latch
        set_evt(16'hFFFF); idle(5); set_evt(16'h0); idle(5);
        @(negedge clk); chk(bus_rdata, 16'h0, "R4 disabled sources");

        // R2 + R7 latency on bit 4
        wr(2'd0, 16'h00F0);
        @(posedge clk); #5; evt_in = 16'h0010;   // sampled at edge k
        @(posedge clk);                          // k
        @(posedge clk); @(negedge clk);          // after k+1
        chk(bus_rdata & 16'h0010, 16'h0, "R7 not yet after k+1");
        @(posedge clk); @(negedge clk);          // after k+2
        chk(bus_rdata & 16'h0010, 16'h0010, "R7 set after k+2");
        @(negedge clk);
        chk({15'h0, irq}, 16'h1, "R6 irq one cycle later");

        // R4: writes to status are ignored
        wr(2'd2, 16'h0000);
        @(negedge clk); chk(bus_rdata, 16'h0010, "R4 status write ignored");

        // R5 clear handshake, edge during hold lost
        wr(2'd3, 16'h0010);
        set_evt(16'h0); set_evt(16'h0010); idle(4);
        @(negedge clk); chk(bus_rdata & 16'h0010, 16'h0, "R5 held during clear");
        wr(2'd3, 16'h0);
        idle(4);
        @(negedge clk); chk(bus_rdata, 16'h0, "R5 edge in hold lost");
        chk({15'h0, irq}, 16'h0, "R6 irq low after clear");
        set_evt(16'h0); set_evt(16'h0010); idle(4);
        @(negedge clk); chk(bus_rdata, 16'h0010, "R5 recording resumes");
        ack(16'hFFFF);

        // R3 falling and both edges; R1 extremes bit 0 and 15
        wr(2'd1, 16'h8001); wr(2'd0, 16'h0001);
        set_evt(16'h8001); idle(4);
        @(negedge clk); chk(bus_rdata, 16'h0001, "R1 bit0 rising, bit15 not");
        set_evt(16'h0000); idle(4);
        @(negedge clk); chk(bus_rdata, 16'h8001, "R3 bit15 falling");
        ack(16'h0001);
        set_evt(16'h0001); idle(4);
        @(negedge clk); chk(bus_rdata, 16'h8001, "R3 both edges rise");
        ack(16'h0001);
        set_evt(16'h0000); idle(4);
        @(negedge clk); chk(bus_rdata, 16'h8001, "R3 both edges fall");
        ack(16'hFFFF);

        // R9 converter-done slot
        wr(2'd0, 16'h0800);
        set_evt(16'h0800); idle(5); set_evt(16'h0);
        @(negedge clk); chk(bus_rdata, 16'h0, "R9 bus bit11 ignored");
        @(posedge clk); #5; adc_done = 1'b1; idle(4);
        @(negedge clk); chk(bus_rdata, 16'h0800, "R9 done strobe latches");
        @(posedge clk); #5; adc_done = 1'b0;
        ack(16'hFFFF);

        // random traffic against the reference
        for (int n = 0; n < 3000; n++) begin
            @(posedge clk); #5;
            bus_we = 1'b0; bus_addr = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 3) == 0) evt_in = evt_in ^ 16'($urandom);
            if ($urandom_range(0, 7) == 0) adc_done = ~adc_done;
            if ($urandom_range(0, 9) == 0) begin
                bus_we = 1'b1;
                bus_wdata = (bus_addr == 2'd3 && $urandom_range(0, 1) == 0) ? 16'h0 : 16'($urandom);
            end
        end
        @(posedge clk); #5; bus_we = 1'b0;
        idle(3);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule